// File: doc/BRIEF.md
# Serial bit clock and frame-sync generator

This block derives the timing skeleton of a synchronous serial port from a fast oscillator clock. An 8-bit prescale modulus and an optional fixed divide-by-eight stage set the bit clock. A 2-bit word-length select sets how many bits make up a word. A 5-bit frame divider sets how many words make up a frame. The block produces the bit clock level and a one-cycle strobe that marks the end of each bit. It also produces a strobe on the last bit of each word, a slot index, and a frame-sync pulse that lasts either one bit or one whole word.

Configuration arrives on plain input ports. The prescaler, word-length and sync-length settings act immediately. The frame divider is shadowed and only takes effect at a frame boundary, and a late change is held back for one extra frame. A frame divider of zero gives single-slot framing, which behaves differently in normal mode and in network mode. The block does not shift data and has no register bus.

Top module: `sck_timing_gen`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `slot` is 0, `bclk`, `bit_stb` and `word_end` are 0, and the counters sit at bit 0 of slot 0. With a frame divider above zero in 1-bit sync mode, `fsync` is 1 at that point.
- R2: With `pre8_en` low, one bit lasts 4·(`pm_mod`+1) oscillator cycles. `bclk` is low for the first half of the bit and high for the second half. `bit_stb` is high only in the final cycle of each bit.
- R3: With `pre8_en` high, one bit lasts 32·(`pm_mod`+1) oscillator cycles, with the same half-low, half-high shape.
- R4: `wl_sel` encodes the word length as 00 = 8 bits, 01 = 12 bits, 10 = 16 bits and 11 = 16 bits. `word_end` is high exactly in the `bit_stb` cycle of the last bit of each word.
- R5: `slot` advances by one after each `word_end` and wraps from the frame divider value D back to 0, so a frame holds D+1 words.
- R6: With `fs_long` = 0 and D > 0, `fsync` is high during bit 0 of slot 0 and low at all other times.
- R7: With `fs_long` = 1 and D > 0, `fsync` is high during every bit of slot 0 and low in the other slots.
- R8: With `net_mode` = 0 and D = 0, every word is slot 0. `fsync` is high during bit 0 of every word, whatever the value of `fs_long`.
- R9: With `net_mode` = 1 and D = 0, `fsync` stays low while `slot` stays 0.
- R10: A `frame_div` value present at a clock edge while the last slot of a frame is in bit 0 or bit 1 sets the length of the next frame.
- R11: A `frame_div` change made from bit 2 of the last slot onward does not alter the next frame. It sets the length of the frame after that one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| pm_mod | input | 8 | Prescale modulus; the bit lasts 4·(value+1) prescaled cycles |
| pre8_en | input | 1 | Inserts the fixed divide-by-eight stage |
| frame_div | input | 5 | Words per frame minus one |
| wl_sel | input | 2 | Word length select |
| fs_long | input | 1 | 1: frame sync lasts one word; 0: one bit |
| net_mode | input | 1 | 1: network mode; 0: normal mode |
| bclk | output | 1 | Bit clock level |
| bit_stb | output | 1 | High in the last oscillator cycle of each bit |
| word_end | output | 1 | High in the last oscillator cycle of each word |
| fsync | output | 1 | Frame-sync pulse |
| slot | output | 5 | Current slot index within the frame |

## Verification
All counters are registered and all strobes are decoded from them. A configuration value applied on one clock edge therefore shows in `bit_stb`, `word_end` and `fsync` from the next edge onward. The bench measures intervals rather than absolute cycle numbers: it samples on falling edges, locks onto a strobe, and counts cycles, bit strobes or word strobes up to and including the next one. Each frame-divider change is driven on the second cycle of a chosen bit of the last slot, so the whole bit lies on one side of the capture boundary. The effect is then measured on the frame it must govern, which is one or two frames after the change.

// File: rtl/sck_timing_pkg.sv
package sck_timing_pkg;
   localparam int BIT_W = 5;

   typedef enum logic [1:0] {
      WLEN_8   = 2'b00,
      WLEN_12  = 2'b01,
      WLEN_16  = 2'b10,
      WLEN_16X = 2'b11
   } wlen_e;

   function automatic logic [BIT_W-1:0] wlen_bits(input logic [1:0] code);
      case (wlen_e'(code))
         WLEN_8:  return BIT_W'(8);
         WLEN_12: return BIT_W'(12);
         default: return BIT_W'(16);
      endcase
   endfunction
endpackage

// File: rtl/sck_prescale.sv
module sck_prescale #(
   parameter int PM_W      = 8,
   parameter int FIXED_DIV = 8
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [PM_W-1:0] pm_mod,
   input  logic            pre8_en,
   output logic            bclk,
   output logic            bit_stb
);
   logic            pre_en;
   logic [PM_W-1:0] pm_cnt;
   logic [1:0]      qtr;
   logic            q_wrap;

   generate
      if (FIXED_DIV > 1) begin : g_fixed
         localparam int FD_W = $clog2(FIXED_DIV);
         logic [FD_W-1:0] fd_cnt;
         always_ff @(posedge clk) begin
            if (rst || !pre8_en) fd_cnt <= '0;
            else                 fd_cnt <= fd_cnt + FD_W'(1);
         end
         assign pre_en = !pre8_en || (fd_cnt == FD_W'(FIXED_DIV - 1));
      end else begin : g_none
         logic unused_sel;
         assign unused_sel = pre8_en;
         assign pre_en     = 1'b1;
      end
   endgenerate

   // a quarter of a bit ends when the modulus counter reaches pm_mod
   assign q_wrap = pre_en && (pm_cnt >= pm_mod);

   always_ff @(posedge clk) begin
      if (rst) begin
         pm_cnt <= '0;
         qtr    <= 2'd0;
      end else if (pre_en) begin
         if (pm_cnt >= pm_mod) begin
            pm_cnt <= '0;
            qtr    <= qtr + 2'd1;
         end else begin
            pm_cnt <= pm_cnt + PM_W'(1);
         end
      end
   end

   assign bclk    = qtr[1];
   assign bit_stb = q_wrap && (qtr == 2'd3);
endmodule

// File: rtl/sck_word_cnt.sv
module sck_word_cnt
   import sck_timing_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic             bit_stb,
   input  logic [1:0]       wl_sel,
   output logic [BIT_W-1:0] bit_idx,
   output logic             word_end
);
   logic [BIT_W-1:0] last_idx;
   logic             at_last;

   assign last_idx = wlen_bits(wl_sel) - BIT_W'(1);
   // >= keeps the count bounded when the word length shrinks mid-word
   assign at_last  = (bit_idx >= last_idx);
   assign word_end = bit_stb && at_last;

   always_ff @(posedge clk) begin
      if (rst)          bit_idx <= '0;
      else if (bit_stb) bit_idx <= at_last ? '0 : bit_idx + BIT_W'(1);
   end
endmodule

// File: rtl/sck_frame_cnt.sv
module sck_frame_cnt
   import sck_timing_pkg::*;
#(
   parameter int DC_W     = 5,
   parameter int LOCK_BIT = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             word_end,
   input  logic [BIT_W-1:0] bit_idx,
   input  logic [DC_W-1:0]  frame_div,
   input  logic             net_mode,
   input  logic             fs_long,
   output logic [DC_W-1:0]  slot,
   output logic             fsync
);
   logic [DC_W-1:0] dc_active;
   logic [DC_W-1:0] dc_pending;
   logic            last_slot;
   logic            locked;
   logic            single;
   logic            first_bit;

   assign last_slot = (slot >= dc_active);
   assign locked    = last_slot && (bit_idx >= BIT_W'(LOCK_BIT));
   assign single    = (dc_active == '0);
   assign first_bit = (bit_idx == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         dc_pending <= frame_div;
         dc_active  <= frame_div;
         slot       <= '0;
      end else begin
         if (!locked) dc_pending <= frame_div;
         if (word_end) begin
            if (last_slot) begin
               slot      <= '0;
               dc_active <= dc_pending;
            end else begin
               slot <= slot + DC_W'(1);
            end
         end
      end
   end

   always_comb begin
      if (single)       fsync = !net_mode && first_bit;
      else if (fs_long) fsync = (slot == '0);
      else              fsync = (slot == '0) && first_bit;
   end
endmodule

// File: rtl/sck_timing_gen.sv
module sck_timing_gen
   import sck_timing_pkg::*;
#(
   parameter int PM_W      = 8,
   parameter int DC_W      = 5,
   parameter int FIXED_DIV = 8,
   parameter int LOCK_BIT  = 2
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [PM_W-1:0] pm_mod,
   input  logic            pre8_en,
   input  logic [DC_W-1:0] frame_div,
   input  logic [1:0]      wl_sel,
   input  logic            fs_long,
   input  logic            net_mode,
   output logic            bclk,
   output logic            bit_stb,
   output logic            word_end,
   output logic            fsync,
   output logic [DC_W-1:0] slot
);
   localparam int MIN_WORD = 8;

   generate
      if (PM_W < 1 || PM_W > 16) begin : g_bad_pm
         $error("PM_W must lie in 1..16");
      end
      if (DC_W < 1 || DC_W > 8) begin : g_bad_dc
         $error("DC_W must lie in 1..8");
      end
      if (FIXED_DIV < 1 || (FIXED_DIV & (FIXED_DIV - 1)) != 0) begin : g_bad_fd
         $error("FIXED_DIV must be a power of two");
      end
      if (LOCK_BIT < 0 || LOCK_BIT >= MIN_WORD) begin : g_bad_lock
         $error("LOCK_BIT must fall inside the shortest word");
      end
   endgenerate

   logic [BIT_W-1:0] bit_idx;

   sck_prescale #(.PM_W(PM_W), .FIXED_DIV(FIXED_DIV)) u_pre (
      .clk(clk), .rst(rst), .pm_mod(pm_mod), .pre8_en(pre8_en),
      .bclk(bclk), .bit_stb(bit_stb)
   );

   sck_word_cnt u_word (
      .clk(clk), .rst(rst), .bit_stb(bit_stb), .wl_sel(wl_sel),
      .bit_idx(bit_idx), .word_end(word_end)
   );

   sck_frame_cnt #(.DC_W(DC_W), .LOCK_BIT(LOCK_BIT)) u_frame (
      .clk(clk), .rst(rst), .word_end(word_end), .bit_idx(bit_idx),
      .frame_div(frame_div), .net_mode(net_mode), .fs_long(fs_long),
      .slot(slot), .fsync(fsync)
   );
endmodule

// File: rtl/sck_timing_chk.sv
module sck_timing_chk #(
   parameter int DC_W = 5
) (
   input logic            clk,
   input logic            rst,
   input logic            bclk,
   input logic            bit_stb,
   input logic            word_end,
   input logic            fsync,
   input logic [DC_W-1:0] slot
);
   assert_stb_in_high_half_R2: assert property (@(posedge clk) disable iff (rst)
      bit_stb |-> bclk);
   assert_low_after_stb_R2: assert property (@(posedge clk) disable iff (rst)
      bit_stb |=> !bclk);
   assert_word_end_on_bit_R4: assert property (@(posedge clk) disable iff (rst)
      word_end |-> bit_stb);
   assert_slot_step_R5: assert property (@(posedge clk) disable iff (rst)
      word_end |=> (slot == '0 || slot == $past(slot) + DC_W'(1)));
   assert_slot_hold_R5: assert property (@(posedge clk) disable iff (rst)
      !word_end |=> $stable(slot));
   assert_fsync_in_slot0_R6: assert property (@(posedge clk) disable iff (rst)
      fsync |-> (slot == '0));
endmodule

bind sck_timing_gen sck_timing_chk #(.DC_W(DC_W)) u_chk (
   .clk(clk), .rst(rst), .bclk(bclk), .bit_stb(bit_stb),
   .word_end(word_end), .fsync(fsync), .slot(slot)
);

// File: tb/tb_sck_timing_gen.sv
module tb_sck_timing_gen;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] pm_mod = '0;
   logic       pre8_en = 1'b0;
   logic [4:0] frame_div = 5'd3;
   logic [1:0] wl_sel = 2'b00;
   logic       fs_long = 1'b0;
   logic       net_mode = 1'b0;
   logic       bclk, bit_stb, word_end, fsync;
   logic [4:0] slot;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   sck_timing_gen dut (
      .clk(clk), .rst(rst), .pm_mod(pm_mod), .pre8_en(pre8_en),
      .frame_div(frame_div), .wl_sel(wl_sel), .fs_long(fs_long),
      .net_mode(net_mode), .bclk(bclk), .bit_stb(bit_stb),
      .word_end(word_end), .fsync(fsync), .slot(slot)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic restart(input int pm, input bit d8, input int dc, input int wl,
                          input bit fl, input bit nm);
      @(negedge clk);
      pm_mod = 8'(pm); pre8_en = d8; frame_div = 5'(dc); wl_sel = 2'(wl);
      fs_long = fl; net_mode = nm; rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   // R1: state on the first cycle after reset release
   task automatic t_reset();
      restart(0, 1'b0, 3, 0, 1'b0, 1'b0);
      check("R1", "slot", int'(slot), 0);
      check("R1", "bclk", int'(bclk), 0);
      check("R1", "bit_stb", int'(bit_stb), 0);
      check("R1", "word_end", int'(word_end), 0);
      check("R1", "fsync", int'(fsync), 1);
   endtask

   // R2 / R3: bit length and bclk duty
   task automatic t_bit(input string req, input int pm, input bit d8);
      int cyc = 0;
      int hi  = 0;
      int exp = 4 * (pm + 1) * (d8 ? 8 : 1);
      restart(pm, d8, 3, 0, 1'b0, 1'b0);
      while (!bit_stb) @(negedge clk);
      do begin
         @(negedge clk);
         cyc++;
         if (bclk) hi++;
      end while (!bit_stb);
      check(req, "bit period", cyc, exp);
      check(req, "bclk high cycles", hi, exp / 2);
   endtask

   // R4: bits per word
   task automatic t_word(input int wl, input int exp);
      int n = 0;
      restart(0, 1'b0, 3, wl, 1'b0, 1'b0);
      while (!word_end) @(negedge clk);
      do begin
         @(negedge clk);
         if (bit_stb) n++;
      end while (!word_end);
      check("R4", $sformatf("bits per word code %0d", wl), n, exp);
   endtask

   // measures the frame starting at the current cycle; returns at next frame start
   task automatic measure_frame(output int words, output int fs_cyc, output int max_slot);
      int pv;
      words = 0; fs_cyc = 0; max_slot = 0;
      forever begin
         if (fsync) fs_cyc++;
         if (word_end) words++;
         if (int'(slot) > max_slot) max_slot = int'(slot);
         pv = int'(slot);
         @(negedge clk);
         if (slot == 5'd0 && pv != 0) break;
      end
   endtask

   // R5, R6, R7: multi-slot framing and sync width (pm=0, 8-bit words: bit=4 cycles)
   task automatic t_frame(input int dc, input bit fl);
      int w, f, m;
      restart(0, 1'b0, dc, 0, fl, 1'b0);
      measure_frame(w, f, m);
      check("R5", $sformatf("words in frame dc=%0d", dc), w, dc + 1);
      check("R5", $sformatf("highest slot dc=%0d", dc), m, dc);
      if (fl) check("R7", "word-long fsync cycles", f, 8 * 4);
      else    check("R6", "bit-long fsync cycles", f, 4);
   endtask

   // R8, R9: single-slot framing over three words
   task automatic t_single(input bit nm, input bit fl);
      int fs = 0;
      int nw = 0;
      int bad = 0;
      restart(0, 1'b0, 0, 0, fl, nm);
      while (!word_end) @(negedge clk);
      do begin
         @(negedge clk);
         if (fsync) fs++;
         if (word_end) nw++;
         if (slot != 5'd0) bad++;
      end while (nw < 3);
      if (nm) begin
         check("R9", "network single-slot fsync cycles", fs, 0);
         check("R9", "network single-slot nonzero slots", bad, 0);
      end else begin
         check("R8", $sformatf("normal single-slot fsync cycles fs_long=%0d", fl), fs, 3 * 4);
         check("R8", "normal single-slot nonzero slots", bad, 0);
      end
   endtask

   // move into bit b of slot s, second cycle of that bit (pm=0)
   task automatic goto_slot_bit(input int s, input int b);
      while (int'(slot) != s) @(negedge clk);
      repeat (b) begin
         while (!bit_stb) @(negedge clk);
         @(negedge clk);
      end
      @(negedge clk);
   endtask

   task automatic goto_frame_start();
      int pv = int'(slot);
      forever begin
         @(negedge clk);
         if (slot == 5'd0 && pv != 0) break;
         pv = int'(slot);
      end
   endtask

   // R10, R11: frame divider shadowing
   task automatic t_dc_change();
      int w, f, m;
      restart(0, 1'b0, 3, 0, 1'b0, 1'b0);
      goto_slot_bit(3, 1);
      frame_div = 5'd5;
      goto_frame_start();
      measure_frame(w, f, m);
      check("R10", "frame after early change", w, 6);
      goto_slot_bit(5, 2);
      frame_div = 5'd2;
      goto_frame_start();
      measure_frame(w, f, m);
      check("R11", "frame after late change", w, 6);
      measure_frame(w, f, m);
      check("R11", "second frame after late change", w, 3);
   endtask

   initial begin
      t_reset();
      t_bit("R2", 0, 1'b0);
      t_bit("R2", 2, 1'b0);
      t_bit("R2", 255, 1'b0);
      t_bit("R3", 1, 1'b1);
      t_word(0, 8);
      t_word(1, 12);
      t_word(2, 16);
      t_word(3, 16);
      t_frame(3, 1'b0);
      t_frame(3, 1'b1);
      t_frame(26, 1'b0);
      t_single(1'b0, 1'b0);
      t_single(1'b0, 1'b1);
      t_single(1'b1, 1'b0);
      t_dc_change();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1_000_000;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule